// File: doc/BRIEF.md
# Size-Typed Integer ALU

This unit performs integer arithmetic, bitwise logic, shifts and compares on two 64-bit operands. Every operation also carries an operand size (8, 16, 32 or 64 bits) and a signedness flag. Together they give eight integer types. The unit treats the operands as values of the selected type. It writes back a full 64-bit word that always lies inside that type's range, so a later instruction never sees leftover high bits.

Arithmetic wraps. The low size bits of the full-width result are kept, and the word is then sign-extended or zero-extended from the top bit of the selected size. Compares look only at the low size bits of each operand and return a small flag mask. The unit has one register stage: a request presented with `in_valid` produces its result one clock later, flagged by `out_valid`.

Top module: `styp_alu`

## Requirements
- R1: Encodings are as follows. `in_size` 0 selects 8 bits, 1 selects 16, 2 selects 32 and 3 selects 64. `in_signed` = 1 selects signed. `in_op` 0 is add, 1 is subtract, 2 is and, 3 is or, 4 is xor, 5 is shift left, 6 is logical shift right, 7 is arithmetic shift right and 8 is compare.
- R2: Add and subtract wrap: the low size bits of the 64-bit sum or difference are kept, whatever the operands' high bits hold.
- R3: Every result is re-extended from bit size-1. A signed result is sign-extended up to bit 63 and an unsigned result is zero-extended.
- R4: And, or and xor act on the operands and are then re-extended as in R3.
- R5: The shift amount is `in_b` modulo the size. Shift left and logical shift right act on the zero-extended low size bits of `in_a`. Arithmetic shift right treats bit size-1 of `in_a` as the sign.
- R6: A compare returns bit 0 = equal, bit 1 = a less than b and bit 2 = a greater than b, with bits 63..3 zero. It uses only the low size bits of each operand, interpreted as two's complement when `in_signed` = 1 and as unsigned otherwise.
- R7: With size 64, no extension applies and the result equals a plain 64-bit ALU result.
- R8: `out_valid` equals `in_valid` of the previous clock, and `out_result` then holds that request's result.
- R9: While `in_valid` is low, `out_result` keeps its last value.
- R10: A synchronous active-high `rst` clears `out_valid` and `out_result` to zero.
- R11: Opcodes 9 to 15 produce a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| in_op | input | 4 | Operation code |
| in_size | input | 2 | Operand size select |
| in_signed | input | 1 | 1 = signed type |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand / shift amount |
| out_valid | output | 1 | Result strobe, one clock after request |
| out_result | output | 64 | Range-limited result |

## Verification
Wrong size-lane selection or a wrong extension choice shows up in the very next `out_result`. It appears as high bits that disagree with bit size-1, which both the scoreboard and the range property catch on that cycle. Operands are given deliberate garbage above the selected size, so a compare or an operation that leaks high bits gives a wrong value at once. A wrong shift-amount mask appears only when the amount is at least the size, so shifts are driven with such amounts. A broken capture enable appears as a result that changes during idle cycles.

// File: rtl/styp_pkg.sv
package styp_pkg;

    localparam int XLEN  = 64;
    localparam int NSIZE = 4;
    localparam int SZW   = $clog2(NSIZE);
    localparam int OPW   = 4;
    localparam int SHW   = $clog2(XLEN);

    localparam int FLAG_EQ = 0;
    localparam int FLAG_LT = 1;
    localparam int FLAG_GT = 2;

    typedef enum logic [SZW-1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } size_e;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_SHL  = 4'd5,
        OP_SHR  = 4'd6,
        OP_SHRA = 4'd7,
        OP_CMP  = 4'd8
    } op_e;

    typedef struct packed {
        logic [XLEN-1:0] sx;
        logic [XLEN-1:0] zx;
    } ext_pair_t;

    typedef struct packed {
        op_e             op;
        size_e           sz;
        logic            sgn;
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
    } req_t;

    function automatic int unsigned lane_bits(size_e s);
        return 32'd8 << s;
    endfunction

    function automatic logic [SHW-1:0] shift_mask(size_e s);
        return SHW'(lane_bits(s) - 1);
    endfunction

    function automatic logic fits_size(logic [XLEN-1:0] v, size_e s, logic sg);
        int unsigned w;
        logic ok;
        w  = lane_bits(s);
        ok = 1'b1;
        for (int i = 0; i < XLEN; i++) begin
            if (i >= int'(w)) begin
                if (v[i] != (sg & v[w-1])) ok = 1'b0;
            end
        end
        return ok;
    endfunction

endpackage

// File: rtl/styp_size_ext.sv
module styp_size_ext
    import styp_pkg::*;
#(
    parameter int W     = XLEN,
    parameter int LANES = NSIZE
) (
    input  logic [W-1:0] din,
    input  size_e        sz,
    output ext_pair_t    dout
);
    logic [W-1:0] sx_l [LANES];
    logic [W-1:0] zx_l [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int LW = 8 << g;
        assign sx_l[g] = W'($signed(din[LW-1:0]));
        assign zx_l[g] = W'(din[LW-1:0]);
    end

    always_comb begin
        dout.sx = sx_l[sz];
        dout.zx = zx_l[sz];
    end
endmodule

// File: rtl/styp_alu_core.sv
module styp_alu_core
    import styp_pkg::*;
(
    input  req_t            req,
    input  ext_pair_t       a_ext,
    input  ext_pair_t       b_ext,
    output logic [XLEN-1:0] raw
);
    logic [SHW-1:0] shamt;
    logic           eq_f;
    logic           lt_f;
    logic           gt_f;
    logic [XLEN-1:0] flags;

    always_comb begin
        shamt = req.b[SHW-1:0] & shift_mask(req.sz);
        eq_f  = (a_ext.zx == b_ext.zx);
        if (req.sgn) lt_f = $signed(a_ext.sx) < $signed(b_ext.sx);
        else         lt_f = a_ext.zx < b_ext.zx;
        gt_f  = !eq_f && !lt_f;
        flags = '0;
        flags[FLAG_EQ] = eq_f;
        flags[FLAG_LT] = lt_f;
        flags[FLAG_GT] = gt_f;
    end

    always_comb begin
        case (req.op)
            OP_ADD:  raw = req.a + req.b;
            OP_SUB:  raw = req.a - req.b;
            OP_AND:  raw = req.a & req.b;
            OP_OR:   raw = req.a | req.b;
            OP_XOR:  raw = req.a ^ req.b;
            OP_SHL:  raw = a_ext.zx << shamt;
            OP_SHR:  raw = a_ext.zx >> shamt;
            OP_SHRA: raw = $unsigned($signed(a_ext.sx) >>> shamt);
            OP_CMP:  raw = flags;
            default: raw = '0;
        endcase
    end
endmodule

// File: rtl/styp_alu.sv
module styp_alu
    import styp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [3:0]  in_op,
    input  logic [1:0]  in_size,
    input  logic        in_signed,
    input  logic [63:0] in_a,
    input  logic [63:0] in_b,
    output logic        out_valid,
    output logic [63:0] out_result
);
    req_t            req;
    ext_pair_t       a_ext;
    ext_pair_t       b_ext;
    ext_pair_t       r_ext;
    logic [XLEN-1:0] raw;
    logic [XLEN-1:0] fitted;

    always_comb begin
        req.op  = op_e'(in_op);
        req.sz  = size_e'(in_size);
        req.sgn = in_signed;
        req.a   = in_a;
        req.b   = in_b;
    end

    styp_size_ext u_ext_a (.din(req.a), .sz(req.sz), .dout(a_ext));
    styp_size_ext u_ext_b (.din(req.b), .sz(req.sz), .dout(b_ext));

    styp_alu_core u_core (
        .req   (req),
        .a_ext (a_ext),
        .b_ext (b_ext),
        .raw   (raw)
    );

    styp_size_ext u_ext_r (.din(raw), .sz(req.sz), .dout(r_ext));

    assign fitted = req.sgn ? r_ext.sx : r_ext.zx;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_result <= fitted;
        end
    end
endmodule

// File: rtl/styp_alu_chk.sv
module styp_alu_chk
    import styp_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [3:0]  in_op,
    input logic [1:0]  in_size,
    input logic        in_signed,
    input logic [63:0] in_a,
    input logic [63:0] in_b,
    input logic        out_valid,
    input logic [63:0] out_result
);
    // R8
    a_r8_valid_rise: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r8_valid_drop: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R9
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_result));

    // R3
    a_r3_in_range: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> fits_size(out_result, size_e'($past(in_size)), $past(in_signed)));

    // R6
    a_r6_cmp_mask: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 4'd8) |=>
            (out_result[63:3] == '0 && $countones(out_result[2:0]) == 1));

    // R11
    a_r11_reserved: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op > 4'd8) |=> (out_result == '0));

    // R10
    a_r10_reset: assert property (@(posedge clk)
        rst |=> (!out_valid && out_result == '0));
endmodule

bind styp_alu styp_alu_chk u_chk (.*);

// File: tb/tb_styp_alu.sv
module tb_styp_alu;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [3:0]  in_op;
    logic [1:0]  in_size;
    logic        in_signed;
    logic [63:0] in_a;
    logic [63:0] in_b;
    logic        out_valid;
    logic [63:0] out_result;

    always #4 clk = ~clk;

    styp_alu dut (.*);

    typedef struct {
        logic [63:0] exp;
        string       tag;
    } item_t;

    item_t       sb[$];
    int          n_chk  = 0;
    int          n_fail = 0;
    logic [63:0] last_exp = '0;
    bit          done = 0;

    function automatic logic [63:0] lane_fit(logic [63:0] x, int w, bit s);
        logic [63:0] m;
        logic [63:0] k;
        m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        k = x & m;
        if (s && k[w-1]) k = k | ~m;
        return k;
    endfunction

    function automatic logic [63:0] model(logic [63:0] a, logic [63:0] b,
                                          logic [3:0] op, logic [1:0] sz, bit s);
        int          w;
        logic [63:0] m;
        logic [63:0] av;
        logic [63:0] bv;
        int          amt;
        w   = 8 << sz;
        m   = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        amt = int'(b[5:0]) % w;
        av  = a & m;
        bv  = b & m;
        case (op)
            4'd0: return lane_fit(a + b, w, s);
            4'd1: return lane_fit(a - b, w, s);
            4'd2: return lane_fit(a & b, w, s);
            4'd3: return lane_fit(a | b, w, s);
            4'd4: return lane_fit(a ^ b, w, s);
            4'd5: return lane_fit(av << amt, w, s);
            4'd6: return lane_fit(av >> amt, w, s);
            4'd7: return lane_fit($unsigned($signed(lane_fit(a, w, 1)) >>> amt), w, s);
            4'd8: begin
                if (s) begin
                    av[w-1] = ~av[w-1];
                    bv[w-1] = ~bv[w-1];
                end
                return {61'd0, av > bv, av < bv, av == bv};
            end
            default: return 64'd0;
        endcase
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(string tag, logic [3:0] op, logic [1:0] sz, bit s,
                         logic [63:0] a, logic [63:0] b);
        item_t it;
        @(negedge clk);
        in_valid  = 1'b1;
        in_op     = op;
        in_size   = sz;
        in_signed = s;
        in_a      = a;
        in_b      = b;
        it.exp    = model(a, b, op, sz, s);
        it.tag    = tag;
        sb.push_back(it);
    endtask

    task automatic idle_hold(int n);
        logic [63:0] snap;
        @(negedge clk);
        in_valid = 1'b0;
        in_a     = '1;
        in_b     = 64'h1234;
        @(negedge clk);
        snap = last_exp;
        repeat (n) @(negedge clk);
        check("R9 hold while idle", out_result, snap);
        check("R8 out_valid low when idle", {63'd0, out_valid}, 64'd0);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (!rst && out_valid) begin
                if (sb.size() == 0) begin
                    check("R8 unexpected out_valid", {63'd0, out_valid}, 64'd0);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    last_exp = it.exp;
                    check(it.tag, out_result, it.exp);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    localparam logic [63:0] JUNK = 64'hA5A5_5A5A_C3C3_3C00;

    initial begin
        rst       = 1'b1;
        in_valid  = 1'b0;
        in_op     = '0;
        in_size   = '0;
        in_signed = 1'b0;
        in_a      = '0;
        in_b      = '0;
        repeat (3) @(negedge clk);
        check("R10 reset out_valid", {63'd0, out_valid}, 64'd0);
        check("R10 reset result", out_result, 64'd0);
        rst = 1'b0;

        // R2 wrap, R3 extension
        drive("R2 R3 signed byte add overflow", 4'd0, 2'd0, 1, JUNK | 64'h7F, 64'h1);
        drive("R2 R3 unsigned byte add wrap", 4'd0, 2'd0, 0, JUNK | 64'hFF, 64'h1);
        drive("R2 unsigned half sub underflow", 4'd1, 2'd1, 0, JUNK & ~64'hFFFF, 64'h1);
        drive("R2 R3 signed word sub", 4'd1, 2'd2, 1, 64'h0, 64'h1);
        drive("R3 unsigned word add", 4'd0, 2'd2, 0, 64'hFFFF_FFFF_8000_0000, 64'h0);
        // R4 logic
        drive("R4 signed byte xor", 4'd4, 2'd0, 1, 64'h0F, 64'hFFFF_FF70);
        drive("R4 unsigned half or", 4'd3, 2'd1, 0, JUNK, 64'h8001);
        drive("R4 signed half and", 4'd2, 2'd1, 1, 64'h1_8F00, 64'hF0F0);
        // R5 shifts
        drive("R5 byte shl amount mod size", 4'd5, 2'd0, 0, 64'h101, 64'd9);
        drive("R5 signed byte shl into sign", 4'd5, 2'd0, 1, 64'h01, 64'd7);
        drive("R5 half shr on truncated", 4'd6, 2'd1, 0, 64'hFFFF_8000, 64'd15);
        drive("R5 byte shra sign bit 7", 4'd7, 2'd0, 1, 64'h80, 64'd1);
        drive("R5 byte shra unsigned result", 4'd7, 2'd0, 0, 64'h80, 64'd3);
        drive("R5 word shra amount 33", 4'd7, 2'd2, 1, 64'h8000_0000, 64'd33);
        // R6 compare
        drive("R6 byte eq ignores high", 4'd8, 2'd0, 0, 64'hFF00_0042, 64'h0042);
        drive("R6 signed byte lt", 4'd8, 2'd0, 1, 64'hFF, 64'h01);
        drive("R6 unsigned byte gt", 4'd8, 2'd0, 0, 64'hFF, 64'h01);
        drive("R6 signed dbl lt", 4'd8, 2'd3, 1, 64'h8000_0000_0000_0000, 64'd0);
        drive("R6 unsigned half gt high junk", 4'd8, 2'd1, 0, 64'h0_8000, 64'hFFFF_0001);
        // R7 doubleword
        drive("R7 dbl add carry out", 4'd0, 2'd3, 1, '1, 64'd2);
        drive("R7 dbl shl 63", 4'd5, 2'd3, 0, 64'd3, 64'd63);
        drive("R7 dbl shra", 4'd7, 2'd3, 0, 64'h8000_0000_0000_0010, 64'd4);
        // R11 reserved
        drive("R11 reserved op 9", 4'd9, 2'd0, 1, '1, '1);
        drive("R11 reserved op 15", 4'd15, 2'd3, 0, 64'h55, 64'h66);
        drive("R1 valid after reserved", 4'd0, 2'd0, 0, 64'd5, 64'd6);
        idle_hold(4);

        // sweep, R1 encodings over all ops, sizes and signs
        for (int op = 0; op < 9; op++) begin
            for (int sz = 0; sz < 4; sz++) begin
                for (int s = 0; s < 2; s++) begin
                    drive("R1 sweep", 4'(op), 2'(sz), s[0],
                          {$urandom, $urandom}, {$urandom, $urandom});
                end
            end
        end
        idle_hold(2);

        // gapped traffic
        for (int i = 0; i < 300; i++) begin
            drive("R8 gapped random", 4'($urandom % 10), 2'($urandom), 1'($urandom),
                  {$urandom, $urandom}, {$urandom, $urandom});
            if (i % 5 == 0) begin
                @(negedge clk);
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        check("R8 scoreboard drained", 64'(sb.size()), 64'd0);
        summary();
    end
endmodule